// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches 32 external interrupt pins and turns activity on them into interrupt requests. Every pin is first brought into the clock domain through a short synchronizer. A per-line trigger code then selects what counts as an event: an active level (high or low) or an edge (rising, falling or either). Each event latches a pending bit. A per-line mask bit decides whether that pending bit reaches an interrupt output.

The 32 lines form four banks of eight, and each bank has its own trigger-code word, mask byte and pending byte. Software reaches them through a plain 32-bit register port with a write strobe and an always-valid read path. Pending bits are cleared by writing ones. The sixteen lines of banks 0 and 1 each drive a dedicated output. Every line in banks 2 and 3 is ORed into a single shared output that the interrupt handler has to demultiplex.

Top module: `extint_top`

## Requirements
- R1: After reset every mask bit reads 1, every pending bit reads 0, every trigger word reads 0, and both interrupt outputs are low.
- R2: The trigger code of line n is held in its bank's trigger word (bank = n/8) at bits (n mod 8)*4+3 down to (n mod 8)*4. Only the lower three bits of that nibble choose the mode, and the whole 32-bit word reads back as it was written.
- R3: Code 0 sets pending on every cycle the synchronized pin is low, and code 1 on every cycle it is high. While that level holds, a write-one clear has no lasting effect.
- R4: Code 2 sets pending on a falling edge, code 3 on a rising edge, and code 4 on either edge of the synchronized pin.
- R5: Codes 5, 6 and 7 never set pending, whatever the pin does.
- R6: A write to a bank's pending register clears each bit where data bit 7:0 is 1 and leaves a bit unchanged where it is 0.
- R7: If a detected event and a write-one clear hit the same line in the same cycle, the pending bit stays set.
- R8: For lines 0 to 15, irqLow[n] is high exactly when line n is pending and its mask bit is 0.
- R9: irqHigh is high exactly when at least one line from 16 to 31 is pending with a mask bit of 0.
- R10: Byte address bits 5:4 select the group (0 trigger words, 1 masks, 2 pending, 3 unused) and bits 3:2 select the bank, so the trigger words sit at 0x00–0x0C, the masks at 0x10–0x1C and the pending registers at 0x20–0x2C. Mask and pending reads return their byte in bits 7:0 with zeros above it. Reads of group 3 return zero, and writes to group 3 change nothing.
- R11: A pin change applied before clock edge k shows up in pending, and on an unmasked output, just after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pins | input | 32 | Asynchronous external interrupt pins |
| busAddr | input | 6 | Register byte address (bits 1:0 ignored) |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irqLow | output | 16 | Dedicated requests for lines 0 to 15 |
| irqHigh | output | 1 | Shared request for lines 16 to 31 |

## Verification
Two things can touch a pending bit in the same cycle: the detector setting it and a software write clearing it. The bench makes them collide on purpose. It times a write-one clear so that it lands on the exact edge where a rising edge on line 5 is detected, and it also issues clears while a level-high line stays active. In both cases the bit must stay set. During the random phase the same collision happens by chance on any line, and each outcome is judged against a cycle-accurate reference model in the bench in which a set always wins over a clear.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int NUM_BANKS  = 4;
  localparam int BANK_LINES = 8;
  localparam int NUM_LINES  = NUM_BANKS * BANK_LINES;
  localparam int FIELD_W    = 4;
  localparam int MODE_W     = 3;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 6;
  localparam int BANK_W     = $clog2(NUM_BANKS);
  localparam int NUM_DIRECT = 16;

  typedef enum logic [MODE_W-1:0] {
    TRIG_LVL_LO = 3'd0,
    TRIG_LVL_HI = 3'd1,
    TRIG_FALL   = 3'd2,
    TRIG_RISE   = 3'd3,
    TRIG_BOTH   = 3'd4
  } trig_e;

  typedef enum logic [1:0] {
    GRP_CFG  = 2'd0,
    GRP_MASK = 2'd1,
    GRP_PEND = 2'd2,
    GRP_NONE = 2'd3
  } regGrp_e;

  typedef struct packed {
    logic [NUM_BANKS-1:0] cfgWr;
    logic [NUM_BANKS-1:0] maskWr;
    logic [NUM_BANKS-1:0] pendClr;
    regGrp_e              rdGrp;
    logic [BANK_W-1:0]    rdBank;
  } regStrobe_t;
endpackage

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regStrobe_t        strb
);
  regGrp_e           grp;
  logic [BANK_W-1:0] bank;
  logic [1:0]        unusedByteLane;

  assign grp            = regGrp_e'(busAddr[5:4]);
  assign bank           = busAddr[3:2];
  assign unusedByteLane = busAddr[1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hitBank;
    assign hitBank          = busWrEn && (bank == BANK_W'(b));
    assign strb.cfgWr[b]    = hitBank && (grp == GRP_CFG);
    assign strb.maskWr[b]   = hitBank && (grp == GRP_MASK);
    assign strb.pendClr[b]  = hitBank && (grp == GRP_PEND);
  end

  assign strb.rdGrp  = grp;
  assign strb.rdBank = bank;
endmodule

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] pins,
  input  regStrobe_t           strb,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  output logic [NUM_LINES-1:0] pendVec,
  output logic [NUM_LINES-1:0] maskVec
);
  logic [SYNC_STAGES-1:0][NUM_LINES-1:0] syncQ;
  logic [NUM_LINES-1:0] syncd, prevQ, detHit, clrVec, pendQ;
  logic [NUM_BANKS-1:0][DATA_W-1:0]     cfgQ;
  logic [NUM_BANKS-1:0][BANK_LINES-1:0] maskQ;

  // Synchronizer chain and previous-sample register for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= pins;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end
  assign syncd = syncQ[SYNC_STAGES-1];

  // Per-line trigger decode
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int BANK = i / BANK_LINES;
    localparam int OFF  = i % BANK_LINES;
    logic [MODE_W-1:0] code;
    logic hit;
    assign code = cfgQ[BANK][OFF*FIELD_W +: MODE_W];
    always_comb begin
      case (code)
        TRIG_LVL_LO: hit = ~syncd[i];
        TRIG_LVL_HI: hit = syncd[i];
        TRIG_FALL:   hit = prevQ[i] & ~syncd[i];
        TRIG_RISE:   hit = ~prevQ[i] & syncd[i];
        TRIG_BOTH:   hit = prevQ[i] ^ syncd[i];
        default:     hit = 1'b0;
      endcase
    end
    assign detHit[i] = hit;
  end

  // Register banks
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_regs
    assign clrVec[b*BANK_LINES +: BANK_LINES] =
      strb.pendClr[b] ? busWdata[BANK_LINES-1:0] : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgQ[b]  <= '0;
        maskQ[b] <= '1;
      end else begin
        if (strb.cfgWr[b])  cfgQ[b]  <= busWdata;
        if (strb.maskWr[b]) maskQ[b] <= busWdata[BANK_LINES-1:0];
      end
    end
    assign maskVec[b*BANK_LINES +: BANK_LINES] = maskQ[b];
  end

  // Pending: a new detection wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= (pendQ & ~clrVec) | detHit;
  end
  assign pendVec = pendQ;

  // Read path
  always_comb begin
    busRdata = '0;
    case (strb.rdGrp)
      GRP_CFG:  busRdata = cfgQ[strb.rdBank];
      GRP_MASK: busRdata[BANK_LINES-1:0] = maskQ[strb.rdBank];
      GRP_PEND: busRdata[BANK_LINES-1:0] = pendQ[strb.rdBank*BANK_LINES +: BANK_LINES];
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/extint_top.sv
module extint_top
  import extint_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       pins,
  input  logic [5:0]        busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [15:0]       irqLow,
  output logic              irqHigh
);
  regStrobe_t           strb;
  logic [NUM_LINES-1:0] pendVec, maskVec, activeVec;

  extint_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strb    (strb)
  );

  extint_datapath #(.SYNC_STAGES(2)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pins     (pins),
    .strb     (strb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .pendVec  (pendVec),
    .maskVec  (maskVec)
  );

  assign activeVec = pendVec & ~maskVec;
  assign irqLow    = activeVec[NUM_DIRECT-1:0];
  assign irqHigh   = |activeVec[NUM_LINES-1:NUM_DIRECT];
endmodule

// File: rtl/extint_chk.sv
module extint_chk (
  input logic        clk,
  input logic        rstN,
  input logic [5:0]  busAddr,
  input logic        busWrEn,
  input logic [31:0] busWdata,
  input logic [31:0] busRdata,
  input logic [15:0] irqLow,
  input logic        irqHigh
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (irqLow == '0 && !irqHigh)); // R1

  AST_PEND_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[5:4] == 2'd2) |-> (busRdata[31:8] == '0)); // R10

  AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[5:4] == 2'd3) |-> (busRdata == '0)); // R10

  AST_MASK_ALL_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[5:2] == 4'h4 && busWdata[7:0] == 8'hFF) |=> (irqLow[7:0] == '0)); // R8

  AST_ZERO_CLEAR_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[5:2] == 4'h8 && busWdata[7:0] == 8'h00)
      |=> ((irqLow[7:0] & $past(irqLow[7:0])) == $past(irqLow[7:0]))); // R6
endmodule

bind extint_top extint_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .irqLow   (irqLow),
  .irqHigh  (irqHigh)
);

// File: tb/tb_extint_top.sv
module tb_extint_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] pins;
  logic [5:0]  busAddr;
  logic        busWrEn;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic [15:0] irqLow;
  logic        irqHigh;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // Reference model state
  logic [31:0] mCfg [4];
  logic [7:0]  mMask [4];
  logic [31:0] mPend, mS1, mS2, mPrev;
  logic [31:0] P;

  extint_top dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic modeHit(input logic [2:0] code, input logic cur, input logic prv);
    case (code)
      3'd0: return !cur;
      3'd1: return cur;
      3'd2: return prv && !cur;
      3'd3: return !prv && cur;
      3'd4: return prv != cur;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] modelRead(input logic [5:0] a);
    case (a[5:4])
      2'd0: return mCfg[a[3:2]];
      2'd1: return {24'h0, mMask[a[3:2]]};
      2'd2: return {24'h0, mPend[a[3:2]*8 +: 8]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] maskFull();
    return {mMask[3], mMask[2], mMask[1], mMask[0]};
  endfunction

  task automatic modelReset();
    for (int b = 0; b < 4; b++) begin mCfg[b] = '0; mMask[b] = 8'hFF; end
    mPend = '0; mS1 = '0; mS2 = '0; mPrev = '0;
  endtask

  task automatic modelEdge(input logic [31:0] p, input logic we, input logic [5:0] a,
                           input logic [31:0] wd);
    logic [31:0] setV, clrV;
    setV = '0; clrV = '0;
    for (int i = 0; i < 32; i++)
      setV[i] = modeHit(mCfg[i/8][(i%8)*4 +: 3], mS2[i], mPrev[i]);
    if (we && a[5:4] == 2'd2) clrV[a[3:2]*8 +: 8] = wd[7:0];
    mPend = (mPend & ~clrV) | setV;
    if (we && a[5:4] == 2'd0) mCfg[a[3:2]] = wd;
    if (we && a[5:4] == 2'd1) mMask[a[3:2]] = wd[7:0];
    mPrev = mS2; mS2 = mS1; mS1 = p;
  endtask

  // One cycle: called just after a falling edge, returns just after the next one
  task automatic step(input logic [31:0] p, input logic we, input logic [5:0] a,
                      input logic [31:0] wd);
    logic [31:0] act;
    pins = p; busWrEn = we; busAddr = a; busWdata = wd;
    #1;
    chk("R10", busRdata, modelRead(a));
    @(posedge clk);
    #1;
    modelEdge(p, we, a, wd);
    @(negedge clk);
    act = mPend & ~maskFull();
    chk("R8", {16'h0, irqLow}, {16'h0, act[15:0]});
    chk("R9", {31'h0, irqHigh}, {31'h0, |act[31:16]});
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(P, 1'b0, 6'h3C, 32'h0);
  endtask

  task automatic readChk(input string req, input logic [5:0] a, input logic [31:0] exp);
    busWrEn = 1'b0; busAddr = a;
    #1;
    chk(req, busRdata, exp);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    P = '1;
    rstN = 1'b0; pins = P; busAddr = '0; busWrEn = 1'b0; busWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
    // R1: reset state
    readChk("R1", 6'h10, 32'h0000_00FF);
    readChk("R1", 6'h1C, 32'h0000_00FF);
    readChk("R1", 6'h28, 32'h0);
    readChk("R1", 6'h0C, 32'h0);
    chk("R1", {15'h0, irqHigh, irqLow}, 32'h0);

    // Bank 0 setup: line0 lvl-lo, 1 code D, 2 fall, 3 lvl-hi, 4 both, 5/6 rise, 7 code B
    step(P, 1'b1, 6'h00, 32'hB334_12D0);
    step(P, 1'b1, 6'h10, 32'h0);
    idle(2);
    step(P, 1'b1, 6'h20, 32'hFF);
    chk("R8", {24'h0, irqLow[7:0]}, 32'h08);

    // R3: clearing a held level has no lasting effect
    step(P, 1'b1, 6'h20, 32'h08);
    chk("R3", {31'h0, irqLow[3]}, 32'h1);

    // R7: rising edge detected in the same cycle as its clear
    P[5] = 1'b0; idle(3);
    P[5] = 1'b1; idle(2);
    step(P, 1'b1, 6'h20, 32'h20);
    chk("R7", {31'h0, irqLow[5]}, 32'h1);

    // R11: latency of two synchronizer stages
    P[6] = 1'b0; idle(3);
    P[6] = 1'b1; idle(2);
    chk("R11", {31'h0, irqLow[6]}, 32'h0);
    idle(1);
    chk("R11", {31'h0, irqLow[6]}, 32'h1);

    // R4: falling and both-edge modes
    P[2] = 1'b0; idle(3);
    chk("R4", {31'h0, irqLow[2]}, 32'h1);
    P[4] = 1'b0; idle(3);
    chk("R4", {31'h0, irqLow[4]}, 32'h1);
    step(P, 1'b1, 6'h20, 32'h10);
    P[4] = 1'b1; idle(3);
    chk("R4", {31'h0, irqLow[4]}, 32'h1);

    // R6: zeros keep, ones clear
    step(P, 1'b1, 6'h20, 32'h0);
    chk("R6", {31'h0, irqLow[2]}, 32'h1);
    step(P, 1'b1, 6'h20, 32'h04);
    chk("R6", {31'h0, irqLow[2]}, 32'h0);

    // R5: disabled code (low bits 5) ignores pin activity
    P[1] = 1'b0; idle(3);
    P[1] = 1'b1; idle(3);
    chk("R5", {31'h0, irqLow[1]}, 32'h0);

    // R2: only low three bits of the nibble matter (code B acts as rising)
    P[7] = 1'b0; idle(3);
    P[7] = 1'b1; idle(3);
    chk("R2", {31'h0, irqLow[7]}, 32'h1);
    readChk("R2", 6'h00, 32'hB334_12D0);

    // R10: unused group is inert
    step(P, 1'b1, 6'h30, 32'hFFFF_FFFF);
    readChk("R10", 6'h30, 32'h0);
    readChk("R10", 6'h14, 32'h0000_00FF);
    readChk("R10", 6'h20, 32'h0000_00F8);

    // R9: shared output for the upper lines
    step(P, 1'b1, 6'h08, 32'h3333_3333);
    step(P, 1'b1, 6'h18, 32'h0);
    step(P, 1'b1, 6'h28, 32'hFF);
    chk("R9", {31'h0, irqHigh}, 32'h0);
    P[20] = 1'b0; idle(3);
    chk("R9", {31'h0, irqHigh}, 32'h0);
    P[20] = 1'b1; idle(3);
    chk("R9", {31'h0, irqHigh}, 32'h1);
    step(P, 1'b1, 6'h18, 32'hFF);
    chk("R9", {31'h0, irqHigh}, 32'h0);

    // Random phase against the reference model (R8, R9, R10, R7 by chance)
    for (int n = 0; n < 4000; n++) begin
      logic we;
      logic [5:0] a;
      logic [31:0] wd;
      P  = P ^ ($urandom & $urandom & $urandom);
      we = ($urandom % 10) < 3;
      a  = 6'($urandom);
      wd = $urandom;
      if (a[5:4] == 2'd1 && ($urandom % 2 == 0)) wd[7:0] = 8'h00;
      step(P, we, a, wd);
    end

    finishRun();
  end
endmodule